// File: doc/BRIEF.md
# Synchronous Burst SRAM with Shared Data Bus

This block is a clocked static memory with one bidirectional data bus. On every rising clock edge it samples three chip selects, two address strobes (one for a host processor, one for a memory controller), a burst-advance input, the write controls and the address. From these it decides whether to start an access, continue or hold a running burst, or deselect. Writes are merged lane by lane into an internal array. Reads are registered and put on the bus in the following cycle, gated by an asynchronous output enable.

A started access loads the address into an address register and clears a two-bit burst counter. Each later cycle with no strobe and the advance input low moves to the next word inside the aligned group of four. The group walks in linear order or in interleaved order, chosen by a select input. A write cycle always releases the bus, even when output enable is low, so an external writer never collides with the block's drivers.

Top module: `burst_sram`

## Requirements
- R1: While reset is held and after its release, until a read has been performed, the block does not drive `dq`.
- R2: When all three selects are active (`sel0_n`=0, `sel1`=1, `sel2_n`=0), `req_ctrl_n`=0 and `req_host_n`=1, and the write controls ask for a write, the word on `dq` is written at `addr` on that edge and no read data follows.
- R3: While `req_host_n` is 0 with all selects active, the edge starts a read whatever `req_ctrl_n` and the write controls are; nothing is written.
- R4: At every access start, `addr` is loaded into the address register and the burst counter restarts at 0.
- R5: `wr_all_n`=0 writes all four 9-bit lanes, whatever `wr_lane_en_n` and `lane_wr_n` are.
- R6: With `wr_all_n`=1 and `wr_lane_en_n`=0, only the lanes whose `lane_wr_n[i]` is 0 are written, lane i being `dq[9i+8:9i]`. With `wr_lane_en_n`=1 and `wr_all_n`=1, nothing is written.
- R7: `dq` is released in any cycle whose write controls ask for a write of at least one lane, even with `oe_n`=0.
- R8: `oe_n`=1 releases `dq` at once, without waiting for a clock edge.
- R9: Read data for an edge appears on `dq` in the cycle after that edge.
- R10: A strobe edge with any select inactive deselects the block: `dq` floats and following strobe-free cycles perform no access.
- R11: With `ilv`=0, strobe-free cycles with `burst_adv_n`=0 visit the aligned group in the order (start + k) mod 4 in the two low address bits.
- R12: With `ilv`=1, the visiting order is start XOR k in the two low address bits.
- R13: A strobe-free cycle with `burst_adv_n`=1 stays on the current word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| req_host_n | input | 1 | Host address strobe, active low, has priority |
| req_ctrl_n | input | 1 | Controller address strobe, active low |
| burst_adv_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write of all lanes, active low |
| wr_lane_en_n | input | 1 | Qualifies the lane strobes, active low |
| lane_wr_n | input | 4 | Per-lane write strobes, active low |
| addr | input | 6 | Word address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| dq | inout | 36 | Shared data bus |

## Verification
The memory is first filled through controller-strobe full writes, and single host reads then show that addresses load and that data is one cycle late. Lane-strobe writes with sparse masks, and with the lane enable withheld, separate the full, partial and empty merges. Both strobes low together with write controls set tell the host-priority rule from a controller write. Bursts from a start offset of one are run in both orders, because from that offset the linear and interleaved sequences differ. Output-enable toggles during reads, write cycles with output enable low, and a strobe with one select inactive cover the bus-release cases.

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int LANES   = 4,
  parameter int LANE_W  = 9,
  parameter int AW      = 6,
  parameter int BURST_W = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sel0_n,
  input  logic                      sel1,
  input  logic                      sel2_n,
  input  logic                      req_host_n,
  input  logic                      req_ctrl_n,
  input  logic                      burst_adv_n,
  input  logic                      wr_all_n,
  input  logic                      wr_lane_en_n,
  input  logic [LANES-1:0]          lane_wr_n,
  input  logic [AW-1:0]             addr,
  input  logic                      oe_n,
  input  logic                      ilv,
  inout  wire  [LANES*LANE_W-1:0]   dq
);
  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]      mem [DEPTH];
  logic               active_q, rd_q;
  logic [AW-1:0]      base_q;
  logic [BURST_W-1:0] cnt_q, cnt_nxt, lo;
  logic [DW-1:0]      out_q, merged;
  logic [AW-1:0]      eff_addr;
  logic [LANES-1:0]   wmask;

  wire en         = !sel0_n && sel1 && !sel2_n;
  wire any_req    = !req_host_n || !req_ctrl_n;
  wire host_start = en && !req_host_n;
  wire start      = en && any_req;
  wire desel      = any_req && !en;
  wire wr_det     = |wmask;
  wire do_access  = start || (!any_req && active_q);
  wire do_write   = do_access && wr_det && !host_start;
  wire dq_oe      = rd_q && !oe_n && !wr_det;

  assign wmask   = !wr_all_n ? '1 : (!wr_lane_en_n ? ~lane_wr_n : '0);
  assign cnt_nxt = (!any_req && !burst_adv_n) ? cnt_q + BURST_W'(1) : cnt_q;
  assign lo      = ilv ? (base_q[BURST_W-1:0] ^ cnt_nxt) : (base_q[BURST_W-1:0] + cnt_nxt);
  assign eff_addr = start ? addr : {base_q[AW-1:BURST_W], lo};

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign merged[l*LANE_W +: LANE_W] = wmask[l] ? dq[l*LANE_W +: LANE_W]
                                                 : mem[eff_addr][l*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk)
    if (do_write) mem[eff_addr] <= merged;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      base_q   <= '0;
      cnt_q    <= '0;
      out_q    <= '0;
    end else begin
      rd_q <= do_access && !do_write;
      if (do_access && !do_write) out_q <= mem[eff_addr];
      if (start) begin
        active_q <= 1'b1;
        base_q   <= addr;
        cnt_q    <= '0;
      end else if (desel) begin
        active_q <= 1'b0;
      end else if (active_q) begin
        cnt_q <= cnt_nxt;
      end
    end
  end

  assign dq = dq_oe ? out_q : 'z;
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
  parameter int LANES   = 4,
  parameter int BURST_W = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sel0_n,
  input logic               sel1,
  input logic               sel2_n,
  input logic               req_host_n,
  input logic               req_ctrl_n,
  input logic               burst_adv_n,
  input logic               wr_all_n,
  input logic               wr_lane_en_n,
  input logic [LANES-1:0]   lane_wr_n,
  input logic               oe_n,
  input logic               rd_q,
  input logic               active_q,
  input logic [BURST_W-1:0] cnt_q,
  input logic               dq_oe
);
  wire sel_ok = !sel0_n && sel1 && !sel2_n;
  wire wr_in  = !wr_all_n || (!wr_lane_en_n && !(&lane_wr_n));

  a_r2_ctrl_write_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ok && req_host_n && !req_ctrl_n && !wr_all_n) |=> !rd_q);

  a_r3_host_is_read: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ok && !req_host_n) |=> rd_q);

  a_r4_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ok && (!req_host_n || !req_ctrl_n)) |=> (cnt_q == '0));

  a_r7_release_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_in |-> !dq_oe);

  a_r8_oe_release: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe);

  a_r10_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_ok && (!req_host_n || !req_ctrl_n)) |=> (!rd_q && !active_q));

  a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && req_host_n && req_ctrl_n && burst_adv_n) |=> $stable(cnt_q));
endmodule

bind burst_sram burst_sram_chk #(.LANES(LANES), .BURST_W(BURST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
  .req_host_n(req_host_n), .req_ctrl_n(req_ctrl_n), .burst_adv_n(burst_adv_n),
  .wr_all_n(wr_all_n), .wr_lane_en_n(wr_lane_en_n), .lane_wr_n(lane_wr_n),
  .oe_n(oe_n), .rd_q(rd_q), .active_q(active_q), .cnt_q(cnt_q), .dq_oe(dq_oe)
);

// File: tb/burst_sram_tb.sv
module burst_sram_tb;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic sel0_n = 0, sel1 = 1, sel2_n = 0;
  logic req_host_n = 1, req_ctrl_n = 1, burst_adv_n = 1;
  logic wr_all_n = 1, wr_lane_en_n = 1, oe_n = 0, ilv = 0;
  logic [3:0]  lane_wr_n = 4'hF;
  logic [5:0]  addr = 0;
  logic [35:0] wd = 0;
  logic        tb_en = 1;
  logic [35:0] tb_val = 0;
  wire  [35:0] dq;

  assign dq = tb_en ? tb_val : 'z;

  burst_sram u_dut (.clk(clk), .rst_n(rst_n), .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
    .req_host_n(req_host_n), .req_ctrl_n(req_ctrl_n), .burst_adv_n(burst_adv_n),
    .wr_all_n(wr_all_n), .wr_lane_en_n(wr_lane_en_n), .lane_wr_n(lane_wr_n),
    .addr(addr), .oe_n(oe_n), .ilv(ilv), .dq(dq));

  always #(CLK_P/2) clk = ~clk;

  logic [35:0] m_mem [64];
  bit          m_act, m_rd;
  int          m_base, m_cnt;
  logic [35:0] m_out;
  int n_cmp = 0, n_bad = 0;

  function automatic logic [3:0] lanes_of();
    return !wr_all_n ? 4'hF : (!wr_lane_en_n ? ~lane_wr_n : 4'h0);
  endfunction

  task automatic model_edge();
    logic [3:0] mk = lanes_of();
    bit sel = !sel0_n && sel1 && !sel2_n;
    bit req = !req_host_n || !req_ctrl_n;
    bit acc = 0, wr;
    int e = 0;
    if (!rst_n) begin m_act = 0; m_rd = 0; m_cnt = 0; return; end
    if (req && !sel) m_act = 0;
    else if (req) begin m_base = addr; m_cnt = 0; m_act = 1; e = addr; acc = 1; end
    else if (m_act) begin
      if (!burst_adv_n) m_cnt = (m_cnt + 1) % 4;
      e = (m_base / 4) * 4 + (ilv ? ((m_base % 4) ^ m_cnt) : (((m_base % 4) + m_cnt) % 4));
      acc = 1;
    end
    wr = acc && (mk != 0) && !(req && !req_host_n);
    if (wr) for (int l = 0; l < 4; l++) if (mk[l]) m_mem[e][l*9 +: 9] = wd[l*9 +: 9];
    m_rd = acc && !wr;
    if (m_rd) m_out = m_mem[e];
  endtask

  task automatic step(string tag);
    bit wrd = lanes_of() != 0;
    bit drv = m_rd && !oe_n && !wrd;
    logic [35:0] exp = drv ? m_out : (wrd ? wd : 36'h0);
    tb_en  = !drv;
    tb_val = wrd ? wd : 36'h0;
    #(CLK_P/4);
    n_cmp++;
    if (dq !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t dq=%h expected=%h", tag, $time, dq, exp);
    end
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic quiet();
    req_host_n = 1; req_ctrl_n = 1; burst_adv_n = 1;
    wr_all_n = 1; wr_lane_en_n = 1; lane_wr_n = 4'hF;
  endtask

  task automatic ctrl_wr(int a, logic [35:0] d, logic gw, logic be, logic [3:0] bw, string tag);
    quiet(); req_ctrl_n = 0; addr = 6'(a); wd = d;
    wr_all_n = gw; wr_lane_en_n = be; lane_wr_n = bw;
    step(tag);
    quiet();
  endtask

  task automatic host_rd(int a, string tag);
    quiet(); req_host_n = 0; addr = 6'(a); step(tag); quiet();
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    for (int i = 0; i < 3; i++) step("R1 reset");
    rst_n = 1;
    step("R1 idle");
    // R2 R5: fill through controller-strobe full writes, lane strobes high
    for (int a = 0; a < 64; a++)
      ctrl_wr(a, 36'((a + 1) * 36'h0_1357_9BDF) | 36'h1, 1'b0, 1'b1, 4'hF, "R2 R5 fill");
    // R4 R9 R13: single read, then hold
    host_rd(5, "R4 load");
    step("R9 data next cycle");
    step("R13 hold");
    oe_n = 1; step("R8 oe high");
    oe_n = 0; step("R8 oe low again");
    // R7: write with oe low through continue cycle
    host_rd(20, "R4 start");
    wr_all_n = 0; wd = 36'hA_BCDE_F012; step("R7 write releases bus");
    quiet(); step("R7 readback");
    // R6: partial lanes 0 and 2
    ctrl_wr(9, 36'hF_FFFF_FFFF, 1'b1, 1'b0, 4'b1010, "R6 lanes 0,2");
    host_rd(9, "R6 read");
    step("R6 check merge");
    ctrl_wr(9, 36'h5_5555_5555, 1'b1, 1'b1, 4'b0000, "R6 no lane enable");
    step("R6 no write");
    host_rd(9, "R6 reread");
    step("R6 unchanged");
    // R3: both strobes with write controls
    quiet(); req_host_n = 0; req_ctrl_n = 0; wr_all_n = 0; addr = 12; wd = 36'h0_0000_0777;
    step("R3 host priority");
    quiet(); step("R3 old data");
    host_rd(12, "R3 reread"); step("R3 unchanged");
    // R11: linear from offset 1
    ilv = 0;
    host_rd(13, "R11 start");
    burst_adv_n = 0;
    for (int k = 0; k < 5; k++) step("R11 linear");
    quiet();
    // R12: interleaved from offset 1
    ilv = 1;
    host_rd(13, "R12 start");
    burst_adv_n = 0;
    for (int k = 0; k < 5; k++) step("R12 interleaved");
    quiet(); step("R13 hold after burst");
    // R10: deselect
    sel1 = 0; req_ctrl_n = 0; addr = 3; step("R10 deselect edge");
    sel1 = 1; quiet();
    for (int k = 0; k < 3; k++) step("R10 stays idle");
    burst_adv_n = 0; step("R10 no burst");
    quiet();
    sel2_n = 1; req_host_n = 0; step("R10 other select"); sel2_n = 0; quiet();
    step("R10 floats");
    host_rd(13, "R4 after deselect"); step("R9 data");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule